// File: doc/BRIEF.md
# 8-bit CPU dedicated register file

This block keeps the dedicated registers of a small 8-bit processor core: the program counter, the accumulator, the temporary accumulator, the index register, the extra pointer, the stack pointer and the 16-bit program status word. The program status word holds three fields. Bits 15:11 are the register bank number, bits 10:8 are the direct page number, and bits 7:0 are the condition code byte. The instruction sequencer drives the write strobes, and the ALU consumes the register values. Neither of those is part of this block.

Both accumulators have word and byte write modes. A byte write leaves the upper byte alone. A "move" write to the accumulator also pushes the old accumulator contents into the temporary accumulator. The bank and page numbers can also be reached as one byte at a fixed I/O address.

Three combinational address generators are included. The first turns a 3-bit register number into the address of a general-purpose register inside the current bank. The second maps an 8-bit direct operand through the direct page number. The third adds a signed 8-bit displacement to the index register.

Top module: `cpu_dreg_file`

## Requirements
- R1: After reset, pc is 0xFFFD, and acc, tmp, ix, ep, sp and ps are 0x0000.
- R2: When acc_we=1 and acc_word=1, acc takes all 16 bits of acc_wdata on the next clock. When acc_we=1 and acc_word=0, only acc[7:0] takes acc_wdata[7:0], and acc[15:8] keeps its value.
- R3: When acc_we=1 and acc_mov=1, tmp takes the old acc in the same clock. In word mode all 16 bits are copied. In byte mode only tmp[7:0] gets the old acc[7:0], and tmp[15:8] is kept. This transfer overrides tmp_we in the same cycle.
- R4: When tmp_we=1 and no move is in progress, tmp is written like acc. tmp_word=1 writes all 16 bits. tmp_word=0 writes only tmp[7:0].
- R5: pc, ix, ep, sp and ps each load their own wdata on the clock after their we strobe. Without the strobe they hold their value.
- R6: gpr_addr = 0x0100 + ps[15:11]*8 + gpr_sel, which covers 0x0100 to 0x01FF.
- R7: If dir_opnd < 0x80, dir_addr equals dir_opnd whatever ps[10:8] holds. Otherwise dir_addr = ps[10:8]*0x80 + dir_opnd, which gives 0x0080..0x00FF for page 0 and 0x0400..0x047F for page 7.
- R8: ix_addr = ix + sign-extended ix_off, modulo 2^16.
- R9: When io_we=1 and io_addr=0x0078, ps[15:11] takes io_wdata[7:3] and ps[10:8] takes io_wdata[2:0] on the next clock. ps[7:0] does not change. A write to any other io_addr leaves ps unchanged. io_rdata shows ps[15:8] while io_addr=0x0078 and 0x00 otherwise.
- R10: When ps_we and a write at 0x0078 occur in the same cycle, ps takes ps_wdata in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_we | input | 1 | Accumulator write strobe |
| acc_word | input | 1 | 1 = word write, 0 = low byte only |
| acc_mov | input | 1 | Move write: push old accumulator into tmp |
| acc_wdata | input | 16 | Accumulator write data |
| tmp_we | input | 1 | Temporary accumulator write strobe |
| tmp_word | input | 1 | 1 = word write, 0 = low byte only |
| tmp_wdata | input | 16 | Temporary accumulator write data |
| pc_we | input | 1 | Program counter load |
| pc_wdata | input | 16 | Program counter data |
| ix_we | input | 1 | Index register load |
| ix_wdata | input | 16 | Index register data |
| ep_we | input | 1 | Extra pointer load |
| ep_wdata | input | 16 | Extra pointer data |
| sp_we | input | 1 | Stack pointer load |
| sp_wdata | input | 16 | Stack pointer data |
| ps_we | input | 1 | Program status word load |
| ps_wdata | input | 16 | Program status word data |
| io_addr | input | 16 | I/O-side byte address |
| io_we | input | 1 | I/O-side write strobe |
| io_wdata | input | 8 | I/O-side write byte |
| io_rdata | output | 8 | Bank/page byte when the mirror address is selected, else 0 |
| gpr_sel | input | 3 | General-purpose register number |
| gpr_addr | output | 16 | General-purpose register address |
| dir_opnd | input | 8 | Direct addressing operand |
| dir_addr | output | 16 | Mapped direct address |
| ix_off | input | 8 | Signed index displacement |
| ix_addr | output | 16 | Index plus displacement |
| pc | output | 16 | Program counter |
| acc | output | 16 | Accumulator |
| tmp | output | 16 | Temporary accumulator |
| ix | output | 16 | Index register |
| ep | output | 16 | Extra pointer |
| sp | output | 16 | Stack pointer |
| ps | output | 16 | Program status word |

## Verification
A vector table sets the bank/page byte through the mirror address and then applies a register number and a direct operand. Its entries cover both bank extremes, several middle banks, every boundary of the operand's low half, and both ends of page 7. An error in the bank shift, the page scaling or the low-half bypass therefore produces a distinct wrong address. Directed sequences separate word moves from byte moves and from plain byte writes by the contents of the temporary accumulator's high byte. They also apply a move and a direct tmp write in the same cycle. The index adder is tried with a positive displacement that crosses zero, with -128, with +127, and with -1 from zero, so that sign extension and wrap are each observed.

// File: rtl/dreg_pkg.sv
package dreg_pkg;
   localparam int BYTE_W = 8;
   localparam int RP_W   = 5;
   localparam int DP_W   = 3;
   localparam int CCR_W  = 8;
   localparam int SEL_W  = 3;

   typedef struct packed {
      logic [RP_W-1:0]  rp;
      logic [DP_W-1:0]  dp;
      logic [CCR_W-1:0] ccr;
   } ps_t;
endpackage

// File: rtl/dreg_acc_pair.sv
module dreg_acc_pair #(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_we,
   input  logic              acc_word,
   input  logic              acc_mov,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              tmp_we,
   input  logic              tmp_word,
   input  logic [DATA_W-1:0] tmp_wdata,
   output logic [DATA_W-1:0] acc_q,
   output logic [DATA_W-1:0] tmp_q
);
   localparam int LANES = DATA_W / LANE_W;

   logic [DATA_W-1:0] acc_nxt, tmp_nxt;
   logic              push;

   assign push = acc_we && acc_mov;

   generate
      if (LANES * LANE_W != DATA_W) begin : g_bad_lanes
         $error("dreg_acc_pair: DATA_W must be a multiple of LANE_W");
      end
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         localparam bit LOW = (l == 0);
         logic acc_hit, tmp_hit;
         assign acc_hit = acc_we && (LOW || acc_word);
         assign tmp_hit = push ? (LOW || acc_word) : (tmp_we && (LOW || tmp_word));
         assign acc_nxt[l*LANE_W +: LANE_W] = acc_hit ? acc_wdata[l*LANE_W +: LANE_W]
                                                      : acc_q[l*LANE_W +: LANE_W];
         assign tmp_nxt[l*LANE_W +: LANE_W] = !tmp_hit ? tmp_q[l*LANE_W +: LANE_W]
                                            : (push ? acc_q[l*LANE_W +: LANE_W]
                                                    : tmp_wdata[l*LANE_W +: LANE_W]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         tmp_q <= '0;
      end else begin
         acc_q <= acc_nxt;
         tmp_q <= tmp_nxt;
      end
   end

   p_word_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_we && acc_word |=> acc_q == $past(acc_wdata));
   p_byte_keeps_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_we && !acc_word |=> acc_q[DATA_W-1:LANE_W] == $past(acc_q[DATA_W-1:LANE_W]));
   p_word_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
      push && acc_word |=> tmp_q == $past(acc_q));
   p_byte_push_keeps_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      push && !acc_word |=> tmp_q[DATA_W-1:LANE_W] == $past(tmp_q[DATA_W-1:LANE_W]));
   p_tmp_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !push && !tmp_we |=> $stable(tmp_q));
endmodule

// File: rtl/dreg_ptr_bank.sv
module dreg_ptr_bank #(
   parameter int              DATA_W      = 16,
   parameter int              IO_W        = 8,
   parameter int              NPTR        = 4,
   parameter logic [DATA_W-1:0] PC_RESET  = 16'hFFFD,
   parameter logic [DATA_W-1:0] MIRROR_ADDR = 16'h0078
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPTR-1:0]   ld_we,
   input  logic [DATA_W-1:0] ld_data [NPTR],
   output logic [DATA_W-1:0] ld_q    [NPTR],
   input  logic              ps_we,
   input  logic [DATA_W-1:0] ps_wdata,
   input  logic [DATA_W-1:0] io_addr,
   input  logic              io_we,
   input  logic [IO_W-1:0]   io_wdata,
   output logic [IO_W-1:0]   io_rdata,
   output logic [DATA_W-1:0] ps_q
);
   localparam int HI_LO = DATA_W - IO_W;

   logic mirror_sel, mirror_wr;

   generate
      if (HI_LO < 0) begin : g_bad_io
         $error("dreg_ptr_bank: IO_W exceeds DATA_W");
      end
   endgenerate

   assign mirror_sel = (io_addr == MIRROR_ADDR);
   assign mirror_wr  = io_we && mirror_sel;
   assign io_rdata   = mirror_sel ? ps_q[DATA_W-1:HI_LO] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NPTR; i++) ld_q[i] <= (i == 0) ? PC_RESET : '0;
      end else begin
         for (int i = 0; i < NPTR; i++) if (ld_we[i]) ld_q[i] <= ld_data[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         ps_q <= '0;
      else if (ps_we)     ps_q <= ps_wdata;
      else if (mirror_wr) ps_q[DATA_W-1:HI_LO] <= io_wdata;
   end

   p_word_beats_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ps_we |=> ps_q == $past(ps_wdata));
   p_mirror_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mirror_wr && !ps_we |=> ps_q[DATA_W-1:HI_LO] == $past(io_wdata));
   p_mirror_ccr_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ps_we |=> ps_q[HI_LO-1:0] == $past(ps_q[HI_LO-1:0]));
   p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_we[0] |=> ld_q[0] == $past(ld_q[0]));
endmodule

// File: rtl/dreg_addr_gen.sv
module dreg_addr_gen
   import dreg_pkg::*;
#(
   parameter int              DATA_W   = 16,
   parameter logic [BYTE_W-1:0] GPR_PAGE = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RP_W-1:0]   rp,
   input  logic [DP_W-1:0]   dp,
   input  logic [DATA_W-1:0] ix,
   input  logic [SEL_W-1:0]  gpr_sel,
   input  logic [BYTE_W-1:0] dir_opnd,
   input  logic [BYTE_W-1:0] ix_off,
   output logic [DATA_W-1:0] gpr_addr,
   output logic [DATA_W-1:0] dir_addr,
   output logic [DATA_W-1:0] ix_addr
);
   localparam int PAGE_SH = BYTE_W - 1;
   localparam int HI_W    = DATA_W - PAGE_SH;

   generate
      if (BYTE_W + RP_W + SEL_W != DATA_W) begin : g_bad_gpr
         $error("dreg_addr_gen: register address fields must fill DATA_W");
      end
   endgenerate

   logic upper_half;
   assign upper_half = dir_opnd[BYTE_W-1];

   assign gpr_addr = {GPR_PAGE, rp, gpr_sel};
   assign dir_addr = upper_half ? (DATA_W'(dp) << PAGE_SH) + DATA_W'(dir_opnd)
                                : DATA_W'(dir_opnd);
   assign ix_addr  = ix + DATA_W'(signed'(ix_off));

   p_dir_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
      upper_half |-> dir_addr[DATA_W-1:PAGE_SH] == HI_W'(dp) + HI_W'(1));
   p_gpr_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gpr_addr[DATA_W-1:RP_W+SEL_W] == DATA_W'(GPR_PAGE) >> 0);
endmodule

// File: rtl/cpu_dreg_file.sv
module cpu_dreg_file
   import dreg_pkg::*;
#(
   parameter int              DATA_W      = 16,
   parameter logic [15:0]     PC_RESET    = 16'hFFFD,
   parameter logic [15:0]     MIRROR_ADDR = 16'h0078
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_we,
   input  logic              acc_word,
   input  logic              acc_mov,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              tmp_we,
   input  logic              tmp_word,
   input  logic [DATA_W-1:0] tmp_wdata,
   input  logic              pc_we,
   input  logic [DATA_W-1:0] pc_wdata,
   input  logic              ix_we,
   input  logic [DATA_W-1:0] ix_wdata,
   input  logic              ep_we,
   input  logic [DATA_W-1:0] ep_wdata,
   input  logic              sp_we,
   input  logic [DATA_W-1:0] sp_wdata,
   input  logic              ps_we,
   input  logic [DATA_W-1:0] ps_wdata,
   input  logic [DATA_W-1:0] io_addr,
   input  logic              io_we,
   input  logic [BYTE_W-1:0] io_wdata,
   output logic [BYTE_W-1:0] io_rdata,
   input  logic [SEL_W-1:0]  gpr_sel,
   output logic [DATA_W-1:0] gpr_addr,
   input  logic [BYTE_W-1:0] dir_opnd,
   output logic [DATA_W-1:0] dir_addr,
   input  logic [BYTE_W-1:0] ix_off,
   output logic [DATA_W-1:0] ix_addr,
   output logic [DATA_W-1:0] pc,
   output logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] tmp,
   output logic [DATA_W-1:0] ix,
   output logic [DATA_W-1:0] ep,
   output logic [DATA_W-1:0] sp,
   output logic [DATA_W-1:0] ps
);
   localparam int NPTR = 4;

   generate
      if (DATA_W != $bits(ps_t)) begin : g_bad_ps
         $error("cpu_dreg_file: DATA_W must match the status word layout");
      end
   endgenerate

   logic [NPTR-1:0]   ld_we;
   logic [DATA_W-1:0] ld_data [NPTR];
   logic [DATA_W-1:0] ld_q    [NPTR];
   ps_t               ps_view;

   assign ld_we   = {sp_we, ep_we, ix_we, pc_we};
   assign ld_data = '{pc_wdata, ix_wdata, ep_wdata, sp_wdata};
   assign pc      = ld_q[0];
   assign ix      = ld_q[1];
   assign ep      = ld_q[2];
   assign sp      = ld_q[3];
   assign ps_view = ps_t'(ps);

   dreg_acc_pair #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .acc_we(acc_we), .acc_word(acc_word), .acc_mov(acc_mov), .acc_wdata(acc_wdata),
      .tmp_we(tmp_we), .tmp_word(tmp_word), .tmp_wdata(tmp_wdata),
      .acc_q(acc), .tmp_q(tmp)
   );

   dreg_ptr_bank #(.DATA_W(DATA_W), .IO_W(BYTE_W), .NPTR(NPTR),
                   .PC_RESET(PC_RESET), .MIRROR_ADDR(MIRROR_ADDR)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .ld_we(ld_we), .ld_data(ld_data), .ld_q(ld_q),
      .ps_we(ps_we), .ps_wdata(ps_wdata),
      .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .ps_q(ps)
   );

   dreg_addr_gen #(.DATA_W(DATA_W)) u_addr (
      .clk(clk), .rst_n(rst_n),
      .rp(ps_view.rp), .dp(ps_view.dp), .ix(ix),
      .gpr_sel(gpr_sel), .dir_opnd(dir_opnd), .ix_off(ix_off),
      .gpr_addr(gpr_addr), .dir_addr(dir_addr), .ix_addr(ix_addr)
   );
endmodule

// File: tb/cpu_dreg_file_tb.sv
module cpu_dreg_file_tb;
   logic        clk = 0, rst_n = 0;
   logic        acc_we = 0, acc_word = 0, acc_mov = 0, tmp_we = 0, tmp_word = 0;
   logic [15:0] acc_wdata = 0, tmp_wdata = 0;
   logic        pc_we = 0, ix_we = 0, ep_we = 0, sp_we = 0, ps_we = 0, io_we = 0;
   logic [15:0] pc_wdata = 0, ix_wdata = 0, ep_wdata = 0, sp_wdata = 0, ps_wdata = 0;
   logic [15:0] io_addr = 0;
   logic [7:0]  io_wdata = 0, dir_opnd = 0, ix_off = 0;
   logic [2:0]  gpr_sel = 0;
   logic [7:0]  io_rdata;
   logic [15:0] gpr_addr, dir_addr, ix_addr, pc, acc, tmp, ix, ep, sp, ps;
   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   cpu_dreg_file u_dut (.*);

   // {mirror byte, gpr_sel, dir_opnd, expected gpr_addr, expected dir_addr}
   localparam logic [50:0] VEC [8] = '{
      {8'h00, 3'd0, 8'h00, 16'h0100, 16'h0000},
      {8'h00, 3'd7, 8'h80, 16'h0107, 16'h0080},
      {8'hFF, 3'd7, 8'hFF, 16'h01FF, 16'h047F},
      {8'hFF, 3'd0, 8'h7F, 16'h01F8, 16'h007F},
      {8'h07, 3'd3, 8'h80, 16'h0103, 16'h0400},
      {8'h09, 3'd2, 8'h90, 16'h010A, 16'h0110},
      {8'h52, 3'd5, 8'hC4, 16'h0155, 16'h01C4},
      {8'h2B, 3'd1, 8'h10, 16'h0129, 16'h0010}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_we();
      acc_we = 0; acc_mov = 0; tmp_we = 0; pc_we = 0; ix_we = 0;
      ep_we = 0; sp_we = 0; ps_we = 0; io_we = 0;
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      io_addr = 16'h0078;
      #1;
      chk("R1 pc", pc, 16'hFFFD);
      chk("R1 acc", acc, 0); chk("R1 tmp", tmp, 0); chk("R1 ix", ix, 0);
      chk("R1 ep", ep, 0);   chk("R1 sp", sp, 0);   chk("R1 ps", ps, 0);
      chk("R9 rdata at reset", {8'h0, io_rdata}, 16'h0000);

      // table walk: R6, R7, R9
      for (int i = 0; i < 8; i++) begin
         io_addr = 16'h0078; io_we = 1; io_wdata = VEC[i][50:43];
         tick();
         io_we = 0;
         gpr_sel = VEC[i][42:40]; dir_opnd = VEC[i][39:32];
         #1;
         chk("R6 gpr_addr", gpr_addr, VEC[i][31:16]);
         chk("R7 dir_addr", dir_addr, VEC[i][15:0]);
         chk("R9 mirror readback", {8'h0, io_rdata}, {8'h0, VEC[i][50:43]});
         chk("R9 ccr untouched", {8'h0, ps[7:0]}, 16'h0000);
      end

      // R2/R3 word moves
      acc_we = 1; acc_word = 1; acc_mov = 1; acc_wdata = 16'h1234;
      tick();
      acc_wdata = 16'hABCD;
      tick();
      clear_we();
      chk("R2 word acc", acc, 16'hABCD);
      chk("R3 word push", tmp, 16'h1234);
      // byte move
      acc_we = 1; acc_word = 0; acc_mov = 1; acc_wdata = 16'hEE56;
      tick(); clear_we();
      chk("R2 byte move keeps high", acc, 16'hAB56);
      chk("R3 byte push keeps tmp high", tmp, 16'h12CD);
      // plain byte write, no push
      acc_we = 1; acc_word = 0; acc_wdata = 16'h0077;
      tick(); clear_we();
      chk("R2 plain byte", acc, 16'hAB77);
      chk("R3 no push without mov", tmp, 16'h12CD);
      // R4 tmp writes
      tmp_we = 1; tmp_word = 1; tmp_wdata = 16'h9999;
      tick();
      tmp_word = 0; tmp_wdata = 16'h4411;
      tick(); clear_we();
      chk("R4 tmp byte over word", tmp, 16'h9911);
      // R3 priority over tmp_we
      acc_we = 1; acc_word = 1; acc_mov = 1; acc_wdata = 16'h0001;
      tmp_we = 1; tmp_word = 1; tmp_wdata = 16'h5555;
      tick(); clear_we();
      chk("R3 push beats tmp_we", tmp, 16'hAB77);
      chk("R2 acc after push", acc, 16'h0001);

      // R5 loads and hold
      pc_we = 1; pc_wdata = 16'h1000; ix_we = 1; ix_wdata = 16'hFFF0;
      ep_we = 1; ep_wdata = 16'h0ABC; sp_we = 1; sp_wdata = 16'h0200;
      tick(); clear_we();
      tick();
      chk("R5 pc", pc, 16'h1000); chk("R5 ix", ix, 16'hFFF0);
      chk("R5 ep", ep, 16'h0ABC); chk("R5 sp", sp, 16'h0200);

      // R8 index sum
      ix_off = 8'h20; #1;
      chk("R8 positive wrap", ix_addr, 16'h0010);
      ix_we = 1; ix_wdata = 16'h0010; tick(); clear_we();
      ix_off = 8'h80; #1;
      chk("R8 minus 128", ix_addr, 16'hFF90);
      ix_off = 8'h7F; #1;
      chk("R8 plus 127", ix_addr, 16'h008F);
      ix_we = 1; ix_wdata = 16'h0000; tick(); clear_we();
      ix_off = 8'hFF; #1;
      chk("R8 minus one from zero", ix_addr, 16'hFFFF);

      // R9 mirror on a full word
      ps_we = 1; ps_wdata = 16'h00A5; tick(); clear_we();
      chk("R5 ps load", ps, 16'h00A5);
      io_addr = 16'h0078; io_we = 1; io_wdata = 8'hFF; tick(); clear_we();
      chk("R9 mirror write keeps ccr", ps, 16'hFFA5);
      io_addr = 16'h0079; io_we = 1; io_wdata = 8'h00; tick(); clear_we();
      #1;
      chk("R9 other address ignored", ps, 16'hFFA5);
      chk("R9 rdata off mirror", {8'h0, io_rdata}, 16'h0000);

      // R10 conflict
      io_addr = 16'h0078; io_we = 1; io_wdata = 8'h00;
      ps_we = 1; ps_wdata = 16'h1234;
      tick(); clear_we();
      chk("R10 word beats mirror", ps, 16'h1234);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule